// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block serves the two enhanced-mode registers of a printer-port register file: the address register at offset 3 and the data register at offset 4. It also handles the timeout bit of the status register at offset 1. The neighbouring register file holds the control byte and feeds it in as `ctrlReg`. The gate compares that byte against two fixed mode patterns. An access whose direction does not match the current pattern is completed at once and touches nothing on the peripheral side.

An access that matches the pattern becomes a sequence of byte transfers toward the peripheral. Each transfer uses a request / ready / error handshake. Wide data accesses are split into bytes, and the lowest byte goes first. The host sees `hostWait` for as long as the access is in progress, and `hostDone` for exactly one cycle when it finishes.

A byte that the peripheral rejects sets a sticky timeout flag. So does a byte that the peripheral leaves unanswered past a programmable number of cycles. Either event also aborts the rest of the access. Software reads the flag as bit 0 of the status register and clears it by writing a 1 to that bit.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset `hostWait`, `hostDone` and `pReq` are low and the timeout flag is clear, so a status read returns bit 0 = 0. A reset asserted after the flag was set also clears it.
- R2: The mode pattern is formed from control bits 5 (direction), 3, 2, 1 and 0 (mask 0x2F). A write to offset 3 or 4 raises `pReq` only when this pattern equals 0x04. With any other pattern the write completes without any peripheral transfer.
- R3: A read from offset 3 or 4 raises `pReq` only when the masked control byte equals 0x24. With any other pattern the read completes without a transfer and returns all ones at the access width, with zeros above that width.
- R4: `hostSize` 0, 1 and 2 select data accesses of 1, 2 and 4 bytes. Byte k of `hostWdata`/`hostRdata` (bits 8k+7..8k) is the k-th byte moved, counting from k = 0. `pWrite` is 1 for writes and 0 for reads.
- R5: Offset 3 always moves exactly one byte, with `pIsAddr` = 1, whatever `hostSize` says. Offset 4 moves its bytes with `pIsAddr` = 0.
- R6: A cycle with `pReq` and `pErr` both high sets the timeout flag and ends the access. On a read, bytes already accepted keep their values and the remaining bytes of the access width read as 0xFF.
- R7: Each byte holds `pReq` for at most max(`toCycles`,1) cycles. If no answer arrives in that window, the access ends as in R6. A `pReady` in the last allowed cycle completes the byte normally.
- R8: A read from offset 1 completes without a transfer and returns {`periphStatus`[7:1], flag}, zero-extended.
- R9: A write to offset 1 with data bit 0 = 1 clears the flag. The same write with bit 0 = 0 leaves the flag as it was.
- R10: `hostReq` is taken only while `hostWait` is low. `hostDone` is high for exactly one cycle. `hostWait` stays high from the cycle after acceptance through the `hostDone` cycle and is low in the cycle after that.
- R11: When `pReady` and `pErr` arrive in the same cycle, the error takes precedence: the byte is not accepted and R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, sampled while hostWait is low |
| hostWrite | input | 1 | 1 = write access, 0 = read access |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | Data width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| hostWdata | input | 32 | Write data, little-endian |
| hostRdata | output | 32 | Read data, valid while hostDone is high |
| hostWait | output | 1 | Access in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| ctrlReg | input | 8 | Current control register value |
| periphStatus | input | 8 | Status lines from the peripheral |
| toCycles | input | 8 | Per-byte answer window in cycles |
| pReq | output | 1 | Byte transfer request |
| pWrite | output | 1 | Direction of the byte transfer |
| pIsAddr | output | 1 | Transfer targets the address register |
| pWdata | output | 8 | Byte toward the peripheral |
| pRdata | input | 8 | Byte from the peripheral |
| pReady | input | 1 | Peripheral accepted the byte |
| pErr | input | 1 | Peripheral rejected the byte |

## Verification
Two events can land in the same cycle: the peripheral's answer and the expiry of the answer window. The bench sweeps `toCycles` against the peripheral's reply latency so that `pReady` falls inside, exactly on and past the last allowed cycle. For each case it judges the outcome by the read data, the number of request cycles and the flag seen through a status read. A second collision, `pReady` and `pErr` high together, is provoked at every byte position of a four-byte read. The bench expects the error to win, with the right partial data left in place.

// File: rtl/eppgate_pkg.sv
package eppgate_pkg;

  // register offsets that the neighbouring decoder relies on
  localparam logic [2:0] OFS_STATUS  = 3'd1;
  localparam logic [2:0] OFS_EPPADDR = 3'd3;
  localparam logic [2:0] OFS_EPPDATA = 3'd4;

  // control byte: bit5 direction, bit3 select, bit2 init, bit1 autofeed, bit0 strobe
  localparam logic [7:0] MODE_MASK = 8'h2F;
  localparam logic [7:0] MODE_WR   = 8'h04;
  localparam logic [7:0] MODE_RD   = 8'h24;

  localparam int STROBE_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } gateState_t;

  typedef struct packed {
    logic                    load;     // capture host access
    logic                    byteOk;   // peripheral byte accepted
    logic                    errSet;   // error or window expiry
    logic                    flagClr;  // status write with bit0
    logic [STROBE_IDX_W-1:0] idx;      // current byte lane
  } gateStrobe_t;

endpackage

// File: rtl/eppgate_ctrl.sv
module eppgate_ctrl
  import eppgate_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int TO_W       = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostReq,
  input  logic            hostWrite,
  input  logic [2:0]      hostAddr,
  input  logic [1:0]      hostSize,
  input  logic            hostWbit0,
  input  logic [7:0]      ctrlReg,
  input  logic [TO_W-1:0] toCycles,
  input  logic            pReady,
  input  logic            pErr,
  output logic            hostWait,
  output logic            hostDone,
  output logic            pReq,
  output logic            pWrite,
  output logic            pIsAddr,
  output gateStrobe_t     strobe
);

  localparam int LOG_MAX = $clog2(DATA_BYTES);
  localparam int IDX_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  gateState_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] lastNext;
  logic [TO_W-1:0]  waitCnt;
  int               sizeEff;

  logic accept, isEpp, modeOk, startXfer, inXfer, answer, expire;

  always_comb begin
    sizeEff = int'(hostSize);
    if (sizeEff > LOG_MAX) sizeEff = LOG_MAX;
    lastNext = (hostAddr == OFS_EPPDATA) ? IDX_W'((1 << sizeEff) - 1) : '0;
  end

  assign accept    = hostReq && (state == ST_IDLE);
  assign isEpp     = (hostAddr == OFS_EPPADDR) || (hostAddr == OFS_EPPDATA);
  assign modeOk    = hostWrite ? ((ctrlReg & MODE_MASK) == MODE_WR)
                               : ((ctrlReg & MODE_MASK) == MODE_RD);
  assign startXfer = accept && isEpp && modeOk;
  assign inXfer    = (state == ST_XFER);
  assign answer    = pReady || pErr;
  assign expire    = !answer &&
                     (((TO_W+1)'(waitCnt) + (TO_W+1)'(1)) >= (TO_W+1)'(toCycles));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      waitCnt <= '0;
      pWrite  <= 1'b0;
      pIsAddr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= startXfer ? ST_XFER : ST_DONE;
            idx     <= '0;
            waitCnt <= '0;
            lastIdx <= lastNext;
            pWrite  <= hostWrite;
            pIsAddr <= (hostAddr == OFS_EPPADDR);
          end
        end
        ST_XFER: begin
          if (pErr || expire) begin
            state <= ST_DONE;
          end else if (pReady) begin
            if (idx == lastIdx) begin
              state <= ST_DONE;
            end else begin
              idx     <= idx + 1'b1;
              waitCnt <= '0;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hostWait = (state != ST_IDLE);
  assign hostDone = (state == ST_DONE);
  assign pReq     = inXfer;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.byteOk  = inXfer && pReady && !pErr;
    strobe.errSet  = inXfer && (pErr || expire);
    strobe.flagClr = accept && hostWrite && (hostAddr == OFS_STATUS) && hostWbit0;
    strobe.idx     = STROBE_IDX_W'(idx);
  end

  // an access outside its mode pattern never reaches the peripheral (R2, R3)
  assert_gate_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isEpp && !modeOk) |=> !pReq);

  // per-byte request window is bounded (R7)
  assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pReq |-> (waitCnt == '0 || waitCnt < toCycles));

  // completion is a single-cycle pulse (R10)
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  // an error answer always ends the access (R6, R11)
  assert_err_ends_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pReq && pErr) |=> (hostDone && !pReq));

endmodule

// File: rtl/eppgate_dp.sv
module eppgate_dp
  import eppgate_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int DW         = 8 * DATA_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateStrobe_t   strobe,
  input  logic          hostWrite,
  input  logic [2:0]    hostAddr,
  input  logic [1:0]    hostSize,
  input  logic [DW-1:0] hostWdata,
  input  logic [7:0]    periphStatus,
  input  logic [7:0]    pRdata,
  output logic [DW-1:0] hostRdata,
  output logic [7:0]    pWdata,
  output logic          tmoFlag
);

  localparam int LOG_MAX = $clog2(DATA_BYTES);

  logic [DW-1:0] wReg;
  logic [DW-1:0] rReg;
  logic [DW-1:0] onesMask;
  logic          isStatRd;
  int            laneLast;

  assign isStatRd = !hostWrite && (hostAddr == OFS_STATUS);

  always_comb begin
    laneLast = 0;
    if (hostAddr == OFS_EPPDATA) begin
      laneLast = (int'(hostSize) > LOG_MAX) ? (1 << LOG_MAX) - 1 : (1 << int'(hostSize)) - 1;
    end
    for (int b = 0; b < DATA_BYTES; b++) begin
      onesMask[b*8 +: 8] = (b <= laneLast) ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    pWdata = 8'h00;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (int'(strobe.idx) == b) pWdata = wReg[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg    <= '0;
      rReg    <= '0;
      tmoFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        wReg <= hostWdata;
        rReg <= isStatRd ? DW'({periphStatus[7:1], tmoFlag}) : onesMask;
      end
      if (strobe.byteOk) begin
        for (int b = 0; b < DATA_BYTES; b++) begin
          if (int'(strobe.idx) == b) rReg[b*8 +: 8] <= pRdata;
        end
      end
      if (strobe.errSet) tmoFlag <= 1'b1;
      else if (strobe.flagClr) tmoFlag <= 1'b0;
    end
  end

  assign hostRdata = rReg;

  // failed byte latches the sticky flag (R6)
  assert_flag_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errSet |=> tmoFlag);

  // clear request lands when no error competes (R9)
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagClr && !strobe.errSet) |=> !tmoFlag);

  // a load and a byte capture are never issued together (R10)
  assert_load_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.byteOk));

endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import eppgate_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int TO_W       = 8,
  localparam int DW        = 8 * DATA_BYTES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostReq,
  input  logic            hostWrite,
  input  logic [2:0]      hostAddr,
  input  logic [1:0]      hostSize,
  input  logic [DW-1:0]   hostWdata,
  output logic [DW-1:0]   hostRdata,
  output logic            hostWait,
  output logic            hostDone,
  input  logic [7:0]      ctrlReg,
  input  logic [7:0]      periphStatus,
  input  logic [TO_W-1:0] toCycles,
  output logic            pReq,
  output logic            pWrite,
  output logic            pIsAddr,
  output logic [7:0]      pWdata,
  input  logic [7:0]      pRdata,
  input  logic            pReady,
  input  logic            pErr
);

  gateStrobe_t strobe;
  logic        tmoFlag;

  eppgate_ctrl #(.DATA_BYTES(DATA_BYTES), .TO_W(TO_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .hostSize (hostSize),
    .hostWbit0(hostWdata[0]),
    .ctrlReg  (ctrlReg),
    .toCycles (toCycles),
    .pReady   (pReady),
    .pErr     (pErr),
    .hostWait (hostWait),
    .hostDone (hostDone),
    .pReq     (pReq),
    .pWrite   (pWrite),
    .pIsAddr  (pIsAddr),
    .strobe   (strobe)
  );

  eppgate_dp #(.DATA_BYTES(DATA_BYTES)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostWrite   (hostWrite),
    .hostAddr    (hostAddr),
    .hostSize    (hostSize),
    .hostWdata   (hostWdata),
    .periphStatus(periphStatus),
    .pRdata      (pRdata),
    .hostRdata   (hostRdata),
    .pWdata      (pWdata),
    .tmoFlag     (tmoFlag)
  );

  // status access never starts a peripheral transfer (R8)
  assert_status_local_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostWait && hostAddr == OFS_STATUS) |=> !pReq);

  // address register moves a single byte: ready on it ends the access (R5)
  assert_addr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pReq && pIsAddr && pReady) |=> hostDone);

endmodule

// File: tb/tb_epp_cycle_gate.sv
module tb_epp_cycle_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [2:0]  hostAddr = 3'd0;
  logic [1:0]  hostSize = 2'd0;
  logic [31:0] hostWdata = 32'd0;
  logic [31:0] hostRdata;
  logic        hostWait, hostDone;
  logic [7:0]  ctrlReg = 8'hCC;
  logic [7:0]  periphStatus = 8'hA6;
  logic [7:0]  toCycles = 8'd8;
  logic        pReq, pWrite, pIsAddr;
  logic [7:0]  pWdata;
  logic [7:0]  pRdata = 8'd0;
  logic        pReady = 1'b0;
  logic        pErr = 1'b0;

  epp_cycle_gate dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostWait(hostWait), .hostDone(hostDone),
    .ctrlReg(ctrlReg), .periphStatus(periphStatus), .toCycles(toCycles),
    .pReq(pReq), .pWrite(pWrite), .pIsAddr(pIsAddr), .pWdata(pWdata),
    .pRdata(pRdata), .pReady(pReady), .pErr(pErr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // peripheral model state
  int       latency = 0;
  int       errByte = 99;
  bit       bothOnErr = 1'b0;
  logic [7:0] rdBase = 8'h5C;
  int       cnt = 0;
  int       byteNo = 0;
  int       totBytes = 0;
  int       reqCycles = 0;
  logic [7:0] logD [0:7];
  bit       logA [0:7];
  bit       logW [0:7];

  function automatic logic [7:0] rdByte(input logic [7:0] base, input int b);
    return base ^ 8'(b * 29);
  endfunction

  always @(negedge clk) begin
    cycles++;
    pReady = 1'b0;
    pErr   = 1'b0;
    if (!pReq) begin
      cnt = 0;
      byteNo = 0;
    end else begin
      reqCycles++;
      if (cnt == latency) begin
        logD[byteNo] = pWdata;
        logA[byteNo] = pIsAddr;
        logW[byteNo] = pWrite;
        pRdata = rdByte(rdBase, byteNo);
        if (byteNo == errByte) begin
          pErr = 1'b1;
          if (bothOnErr) pReady = 1'b1;
        end else begin
          pReady = 1'b1;
          byteNo++;
          totBytes++;
        end
        cnt = 0;
      end else begin
        cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      errors++;
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one host access; returns read data, bytes accepted, request cycles, handshake ok
  task automatic access(input bit wr, input logic [2:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int nb, output int rc, output bit hsOk);
    int b0, r0, waitN;
    b0 = totBytes;
    r0 = reqCycles;
    hsOk = 1'b1;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = addr; hostSize = size; hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    waitN = 0;
    while (!hostDone && waitN < 300) begin
      if (!hostWait) hsOk = 1'b0;
      @(negedge clk);
      waitN++;
    end
    if (!hostDone) hsOk = 1'b0;
    if (!hostWait) hsOk = 1'b0;
    rd = hostRdata;
    @(negedge clk);
    if (hostDone || hostWait) hsOk = 1'b0;
    nb = totBytes - b0;
    rc = reqCycles - r0;
  endtask

  task automatic readStatus(output logic [31:0] rd);
    int nb, rc;
    bit hs;
    access(1'b0, 3'd1, 2'd0, 32'd0, rd, nb, rc, hs);
  endtask

  task automatic writeStatus(input logic [31:0] v);
    logic [31:0] rd;
    int nb, rc;
    bit hs;
    access(1'b1, 3'd1, 2'd0, v, rd, nb, rc, hs);
  endtask

  initial begin
    logic [31:0] rd, expRd, st;
    int nb, rc, nExp, win;
    bit hs, allowed, ok;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!hostWait && !hostDone && !pReq, "R1 reset outputs",
          {29'd0, hostWait, hostDone, pReq}, 32'd0);
    rstN = 1'b1;
    readStatus(st);
    check(st == {24'd0, periphStatus[7:1], 1'b0}, "R1/R8 status after reset", st,
          {24'd0, periphStatus[7:1], 1'b0});

    // R2, R3, R4, R5, R10: sweep control patterns, directions, offsets, sizes
    for (int c = 0; c < 64; c++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int a = 0; a < 2; a++) begin
          for (int sz = 0; sz < 3; sz++) begin
            logic [31:0] wd;
            logic [2:0]  addr;
            addr = (a == 0) ? 3'd3 : 3'd4;
            ctrlReg = 8'(c) | 8'hC0;
            latency = c % 3;
            errByte = 99;
            rdBase = 8'(c * 7 + sz);
            wd = 32'h9E3779B9 ^ (32'(c) << 8) ^ 32'(wr * 3 + sz);
            allowed = ((ctrlReg & 8'h2F) == (wr ? 8'h04 : 8'h24));
            nExp = (addr == 3'd3) ? 1 : (1 << sz);
            access(wr[0], addr, 2'(sz), wd, rd, nb, rc, hs);
            ok = hs;
            expRd = 32'd0;
            if (!allowed) begin
              ok = ok && (nb == 0) && (rc == 0);
              for (int b = 0; b < nExp; b++) expRd[b*8 +: 8] = 8'hFF;
            end else begin
              ok = ok && (nb == nExp) && (rc == nExp * (latency + 1));
              for (int b = 0; b < nExp; b++) begin
                ok = ok && (logA[b] == (addr == 3'd3)) && (logW[b] == wr[0]);
                if (wr) ok = ok && (logD[b] == wd[b*8 +: 8]);
                expRd[b*8 +: 8] = rdByte(rdBase, b);
              end
            end
            if (!wr) ok = ok && (rd == expRd);
            check(ok, wr ? "R2/R4/R5/R10 write gate" : "R3/R4/R5/R10 read gate",
                  wr ? {16'(nb), 16'(rc)} : rd, wr ? {16'(allowed ? nExp : 0), 16'd0} : expRd);
          end
        end
      end
    end
    readStatus(st);
    check(st[0] == 1'b0, "R6 no flag after clean sweep", st, {st[31:1], 1'b0});

    // R7: answer window versus reply latency, 4-byte read in read mode
    ctrlReg = 8'hE4;
    errByte = 99;
    for (int t = 0; t < 5; t++) begin
      for (int l = 0; l < 6; l++) begin
        toCycles = 8'(t);
        latency = l;
        rdBase = 8'(t * 16 + l);
        win = (t < 1) ? 1 : t;
        access(1'b0, 3'd4, 2'd2, 32'd0, rd, nb, rc, hs);
        if (l + 1 <= win) begin
          for (int b = 0; b < 4; b++) expRd[b*8 +: 8] = rdByte(rdBase, b);
          check(hs && rd == expRd && rc == 4 * (l + 1), "R7 answer inside window", rd, expRd);
        end else begin
          expRd = 32'hFFFFFFFF;
          check(hs && rd == expRd && rc == win && nb == 0, "R7 window expiry", {rd[31:8], 8'(rc)},
                {expRd[31:8], 8'(win)});
        end
        readStatus(st);
        check(st[0] == (l + 1 > win), "R7 flag after window", {31'd0, st[0]}, {31'd0, (l + 1 > win)});
        writeStatus(32'h0);
        readStatus(st);
        check(st[0] == (l + 1 > win), "R9 bit0=0 keeps flag", {31'd0, st[0]}, {31'd0, (l + 1 > win)});
        writeStatus(32'h1);
        readStatus(st);
        check(st == {24'd0, periphStatus[7:1], 1'b0}, "R9/R8 bit0=1 clears flag", st,
              {24'd0, periphStatus[7:1], 1'b0});
      end
    end

    // R6, R11: error at each byte, with and without a coincident ready
    toCycles = 8'd8;
    latency = 1;
    for (int both = 0; both < 2; both++) begin
      for (int j = 0; j < 4; j++) begin
        logic [31:0] wd;
        bothOnErr = both[0];
        errByte = j;
        rdBase = 8'(j * 40 + both);
        periphStatus = 8'(8'h30 + j * 2 + both * 64);
        ctrlReg = 8'h24;
        access(1'b0, 3'd4, 2'd2, 32'd0, rd, nb, rc, hs);
        for (int b = 0; b < 4; b++) expRd[b*8 +: 8] = (b < j) ? rdByte(rdBase, b) : 8'hFF;
        check(hs && rd == expRd && nb == j, both ? "R11 ready+error read" : "R6 error read", rd, expRd);
        readStatus(st);
        check(st == {24'd0, periphStatus[7:1], 1'b1}, "R6/R8 flag set", st,
              {24'd0, periphStatus[7:1], 1'b1});
        writeStatus(32'hFF);
        ctrlReg = 8'h04;
        wd = 32'hC0DE1234 + 32'(j);
        access(1'b1, 3'd4, 2'd2, wd, rd, nb, rc, hs);
        ok = hs && (nb == j);
        for (int b = 0; b < j; b++) ok = ok && (logD[b] == wd[b*8 +: 8]);
        check(ok, both ? "R11 ready+error write" : "R6 error write", 32'(nb), 32'(j));
        readStatus(st);
        check(st[0] == 1'b1, "R6 flag after write error", {31'd0, st[0]}, 32'd1);
        writeStatus(32'h1);
      end
    end
    bothOnErr = 1'b0;

    // R5: address register ignores the size code
    errByte = 99;
    latency = 0;
    ctrlReg = 8'h04;
    access(1'b1, 3'd3, 2'd2, 32'hAABBCC5A, rd, nb, rc, hs);
    check(hs && nb == 1 && logA[0] && logD[0] == 8'h5A, "R5 address single byte", {24'(nb), logD[0]},
          {24'd1, 8'h5A});

    // R1: reset clears a set flag
    errByte = 0;
    ctrlReg = 8'h24;
    access(1'b0, 3'd3, 2'd0, 32'd0, rd, nb, rc, hs);
    errByte = 99;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readStatus(st);
    check(st[0] == 1'b0, "R1 reset clears flag", {31'd0, st[0]}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule